// File: doc/BRIEF.md
# Sixteen-Register Microcoded Datapath

This block is the execution half of a small 16-bit microprogrammed processor. A sequencer outside the block presents one 32-bit microinstruction per clock. The datapath decodes its fields and carries out one register transfer in that cycle:

- It reads two operands from a sixteen-entry register file.
- It picks the left operand from either the register file or the memory buffer.
- It combines the operands in a four-function ALU and passes the result through a one-bit shifter.
- On the closing clock edge it writes the shifted value into a register and/or the memory buffer. It can also load the memory address register from the right-hand operand.

The ALU sign and zero flags are produced combinationally, so the sequencer can branch on them in the same cycle. The read and write strobes go out to memory. Read data returns one cycle after a read request and is captured into the memory buffer. The control store, the next-address logic and the memory are outside this block. The condition and next-address fields of the microinstruction pass through untouched.

Top module: `udp_datapath`

## Requirements
- R1: The microinstruction is decoded most-significant bit first as: A-source select [31], condition [30:29], ALU op [28:27], shift op [26:25], buffer load [24], address load [23], read [22], write [21], register write [20], destination select [19:16], right operand select [15:12], left operand select [11:8], next address [7:0].
- R2: After a synchronous active-low reset, registers 5, 6, 7, 8 and 9 hold 0x0000, 0x0001, 0xFFFF, 0x0FFF and 0x00FF. Every other register, the address register and the buffer register hold zero.
- R3: A-source select 0 feeds the register chosen by the left operand select to the ALU's left input; 1 feeds the memory buffer register.
- R4: ALU op 00 adds the two inputs modulo 2^16, 01 forms their bitwise AND, 10 passes the left input, and 11 forms the bitwise complement of the left input.
- R5: The sign flag equals bit 15 of the ALU result and the zero flag is 1 exactly when the result is zero. Both follow the current microinstruction within the same cycle.
- R6: Shift op 00 passes the ALU result, 01 shifts it right by one and 10 shifts it left by one, the vacated bit filled with 0; op 11 acts as no shift.
- R7: With register write set, the shifter output is stored in the destination register at the closing edge. Operand reads in that cycle see the value held before the edge.
- R8: With buffer load set, the shifter output is stored in the memory buffer register at the closing edge.
- R9: With address load set, the right operand is stored in the address register at the closing edge, and only its low 12 bits drive the memory address output.
- R10: In the cycle after one with read set, the memory buffer captures the memory read data at the closing edge, unless buffer load is set in that cycle, which takes priority. Read data is ignored in any cycle not preceded by a read.
- R11: The read and write strobe outputs equal the read and write fields of the current microinstruction.
- R12: The condition and next-address fields have no effect on any result of the datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| uinstr | input | 32 | Current microinstruction |
| mem_rdata | input | 16 | Read data returned by memory |
| alu_neg | output | 1 | ALU result sign flag |
| alu_zero | output | 1 | ALU result zero flag |
| mem_addr | output | 12 | Memory address (low bits of address register) |
| mbr_out | output | 16 | Memory buffer register contents (also write data) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
Register file contents are not visible at the ports. A corrupted register therefore shows up only when a later microinstruction routes it through the ALU. It then appears at once on the flags, or one edge later in the buffer register. The bench follows every write with such a readout.

A wrong buffer or address register value is visible at the ports one edge after the faulty load. A mis-timed read capture is caught by changing the read data in the following cycle. Flag errors are visible in the same cycle as the microinstruction that causes them.

// File: rtl/mdp_pkg.sv
// Package: shared types for the microcoded datapath.
// Assumes a 32-bit microinstruction whose packed layout (MSB first) is the
// field order the datapath decodes; the struct below encodes that layout.
package mdp_pkg;

    localparam int UWORD_W = 32;
    localparam int SEL_W   = 4;
    localparam int NXT_W   = 8;

    // ALU function codes
    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_AND  = 2'b01,
        ALU_PASS = 2'b10,
        ALU_INV  = 2'b11
    } alu_op_e;

    // Shifter function codes
    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_RSVD  = 2'b11
    } sh_op_e;

    // Microinstruction layout, most significant field first
    typedef struct packed {
        logic             src_mbr;
        logic [1:0]       cond;
        alu_op_e          alu;
        sh_op_e           sh;
        logic             mbr_ld;
        logic             mar_ld;
        logic             rd;
        logic             wr;
        logic             reg_we;
        logic [SEL_W-1:0] c_sel;
        logic [SEL_W-1:0] b_sel;
        logic [SEL_W-1:0] a_sel;
        logic [NXT_W-1:0] nxt;
    } uword_t;

endpackage

// File: rtl/mdp_regfile.sv
// Module: register file with two combinational read ports and one write port.
// Assumes: write happens at the rising edge, so same-cycle reads see old data.
// Registers 5..9 come out of reset holding fixed constants, the rest zero.
module mdp_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] a_sel,
    input  logic [$clog2(NREG)-1:0] b_sel,
    output logic [DATA_W-1:0]       a_data,
    output logic [DATA_W-1:0]       b_data,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] c_sel,
    input  logic [DATA_W-1:0]       c_data
);
    localparam int SEL_W = $clog2(NREG);
    localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ADDR_MASK = ALL_ONES >> (DATA_W - ADDR_W);
    localparam logic [DATA_W-1:0] BYTE_MASK = ALL_ONES >> (DATA_W - BYTE_W);

    logic [DATA_W-1:0] regs_q [NREG];

    // Reset constant for register index idx
    function automatic logic [DATA_W-1:0] rst_val(input int idx);
        case (idx)
            6:       return {{(DATA_W-1){1'b0}}, 1'b1};
            7:       return ALL_ONES;
            8:       return ADDR_MASK;
            9:       return BYTE_MASK;
            default: return '0;
        endcase
    endfunction

    // Storage: reset to constants, else single write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= rst_val(i);
            end
        end else if (we) begin
            regs_q[c_sel] <= c_data;
        end
    end

    // Read ports: combinational, pre-edge values
    always_comb begin
        a_data = regs_q[a_sel];
        b_data = regs_q[b_sel];
    end

    // R7
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(c_sel)] == $past(c_data));

    // R2
    logic [SEL_W-1:0] probe_sel;
    assign probe_sel = SEL_W'(7);
    reg_const_chk: assert property (@(posedge clk)
        !rst_n |=> (regs_q[probe_sel] == ALL_ONES) || !rst_n);

endmodule

// File: rtl/mdp_alu.sv
// Module: four-function ALU with sign and zero flags.
// Assumes: purely combinational; addition wraps modulo 2^DATA_W.
module mdp_alu
    import mdp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  alu_op_e           func,
    output logic [DATA_W-1:0] result,
    output logic              neg,
    output logic              zero
);
    // Function select
    always_comb begin
        unique case (func)
            ALU_ADD:  result = op_a + op_b;
            ALU_AND:  result = op_a & op_b;
            ALU_PASS: result = op_a;
            ALU_INV:  result = ~op_a;
            default:  result = op_a;
        endcase
    end

    // Flags from the result
    always_comb begin
        neg  = result[DATA_W-1];
        zero = (result == '0);
    end

endmodule

// File: rtl/mdp_shifter.sv
// Module: one-bit logical shifter after the ALU.
// Assumes: vacated bit fills with zero; the reserved code passes data through.
module mdp_shifter
    import mdp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] din,
    input  sh_op_e            func,
    output logic [DATA_W-1:0] dout
);
    // Shift select
    always_comb begin
        unique case (func)
            SH_RIGHT: dout = {1'b0, din[DATA_W-1:1]};
            SH_LEFT:  dout = {din[DATA_W-2:0], 1'b0};
            default:  dout = din;
        endcase
    end

endmodule

// File: rtl/udp_datapath.sv
// Module: top of the microcoded datapath. One register transfer per cycle.
// Assumes: the microinstruction is stable for the whole cycle; memory returns
// read data during the cycle after the one that asserted the read field.
// Condition and next-address fields belong to the sequencer and are unused.
module udp_datapath
    import mdp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [UWORD_W-1:0]   uinstr,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 alu_neg,
    output logic                 alu_zero,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mbr_out,
    output logic                 mem_rd,
    output logic                 mem_wr
);
    uword_t            uw;
    logic [DATA_W-1:0] a_data, b_data, alu_a, alu_y, sh_y;
    logic [DATA_W-1:0] mbr_q;
    logic [ADDR_W-1:0] mar_q;
    logic              rd_pend_q;
    logic              unused_fields;

    // Field decode
    assign uw            = uword_t'(uinstr);
    assign unused_fields = ^{uw.cond, uw.nxt, b_data[DATA_W-1:ADDR_W]};

    mdp_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_sel  (uw.a_sel),
        .b_sel  (uw.b_sel),
        .a_data (a_data),
        .b_data (b_data),
        .we     (uw.reg_we),
        .c_sel  (uw.c_sel),
        .c_data (sh_y)
    );

    // Left operand source select
    always_comb begin
        alu_a = uw.src_mbr ? mbr_q : a_data;
    end

    mdp_alu #(.DATA_W(DATA_W)) u_alu (
        .op_a   (alu_a),
        .op_b   (b_data),
        .func   (uw.alu),
        .result (alu_y),
        .neg    (alu_neg),
        .zero   (alu_zero)
    );

    mdp_shifter #(.DATA_W(DATA_W)) u_sh (
        .din  (alu_y),
        .func (uw.sh),
        .dout (sh_y)
    );

    // Memory buffer: shifter load wins over returning read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr_q <= '0;
        end else if (uw.mbr_ld) begin
            mbr_q <= sh_y;
        end else if (rd_pend_q) begin
            mbr_q <= mem_rdata;
        end
    end

    // Memory address: low bits of the right operand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (uw.mar_ld) begin
            mar_q <= b_data[ADDR_W-1:0];
        end
    end

    // Read pending: remembers a read request for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
        end else begin
            rd_pend_q <= uw.rd;
        end
    end

    // Outputs
    assign mem_addr = mar_q;
    assign mbr_out  = mbr_q;
    assign mem_rd   = uw.rd;
    assign mem_wr   = uw.wr;

    // R8
    mbr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uw.mbr_ld |=> mbr_out == $past(sh_y));

    // R10
    rd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend_q && !uw.mbr_ld) |=> mbr_out == $past(mem_rdata));

    // R10
    mbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uw.mbr_ld && !rd_pend_q) |=> $stable(mbr_out));

    // R9
    mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uw.mar_ld |=> mem_addr == $past(b_data[ADDR_W-1:0]));

    // R6
    shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.sh == SH_RIGHT) |-> !sh_y[DATA_W-1]);

    // R6
    shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.sh == SH_LEFT) |-> !sh_y[0]);

    // R4
    inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.alu == ALU_INV) |-> ((alu_y ^ alu_a) == {DATA_W{1'b1}}));

endmodule

// File: tb/sim_udp_datapath.sv
`timescale 1ns/1ps
module sim_udp_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] uinstr = '0;
    logic [15:0] mem_rdata = '0;
    logic        alu_neg, alu_zero, mem_rd, mem_wr;
    logic [11:0] mem_addr;
    logic [15:0] mbr_out;

    always #2 clk = ~clk;   // 250 MHz

    udp_datapath u0 (
        .clk(clk), .rst_n(rst_n), .uinstr(uinstr), .mem_rdata(mem_rdata),
        .alu_neg(alu_neg), .alu_zero(alu_zero), .mem_addr(mem_addr),
        .mbr_out(mbr_out), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    // Scoreboard item: phase 0 = before the edge, 1 = after the edge
    typedef struct {
        int          phase;
        int          kind;    // 0 mbr, 1 addr, 2 neg, 3 zero, 4 rd, 5 wr
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // R1 layout: src[31] cond[30:29] alu[28:27] sh[26:25] mbr[24] mar[23]
    // rd[22] wr[21] we[20] c[19:16] b[15:12] a[11:8] nxt[7:0]
    function automatic logic [31:0] mk(input logic src, input logic [1:0] alu,
        input logic [1:0] sh, input logic mbr, input logic mar, input logic rd,
        input logic wr, input logic we, input logic [3:0] c, input logic [3:0] b,
        input logic [3:0] a);
        return {src, 2'b00, alu, sh, mbr, mar, rd, wr, we, c, b, a, 8'h00};
    endfunction

    function automatic logic [15:0] actual(input int kind);
        case (kind)
            0: return mbr_out;
            1: return {4'h0, mem_addr};
            2: return {15'h0, alu_neg};
            3: return {15'h0, alu_zero};
            4: return {15'h0, mem_rd};
            default: return {15'h0, mem_wr};
        endcase
    endfunction

    task automatic check_item(input item_t it);
        logic [15:0] act;
        act = actual(it.kind);
        checks++;
        if (act !== it.exp) begin
            errors++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
    endtask

    // Monitor: pops combinational items mid-cycle, registered ones after the edge
    initial begin
        forever begin
            @(negedge clk); #1;
            while (q.size() > 0 && q[0].phase == 0) check_item(q.pop_front());
            @(posedge clk); #1;
            while (q.size() > 0 && q[0].phase == 1) check_item(q.pop_front());
        end
    end

    // Driver: applies one microinstruction for one cycle
    task automatic cyc(input logic [31:0] mir, input logic [15:0] rdata);
        @(negedge clk);
        uinstr    = mir;
        mem_rdata = rdata;
    endtask

    task automatic expect_now(input int kind, input logic [15:0] v, input string r);
        item_t it;
        it.phase = 0; it.kind = kind; it.exp = v; it.req = r;
        q.push_back(it);
    endtask

    task automatic expect_next(input int kind, input logic [15:0] v, input string r);
        item_t it;
        it.phase = 1; it.kind = kind; it.exp = v; it.req = r;
        q.push_back(it);
    endtask

    // Register load through a memory read: read, data return, copy buffer to reg
    task automatic load_reg(input logic [3:0] r, input logic [15:0] v);
        cyc(mk(0, 2'b00, 2'b00, 0, 0, 1, 0, 0, 0, 0, 0), 16'h0);
        cyc(32'h0, v);
        cyc(mk(1, 2'b10, 2'b00, 0, 0, 0, 0, 1, r, 0, 0), 16'h0);
    endtask

    // Register readout via ALU pass into the buffer
    task automatic peek(input logic [3:0] r, input logic [15:0] v, input string req);
        cyc(mk(0, 2'b10, 2'b00, 1, 0, 0, 0, 0, 0, 0, r), 16'h0);
        expect_next(0, v, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state of outputs; R11 strobes idle
        cyc(32'h0, 16'h0);
        expect_now(0, 16'h0000, "R2");
        expect_now(1, 16'h0000, "R2");
        expect_now(4, 16'h0, "R11");
        expect_now(5, 16'h0, "R11");
        // R2 constant registers
        peek(4'd5, 16'h0000, "R2");
        peek(4'd6, 16'h0001, "R2");
        peek(4'd7, 16'hFFFF, "R2");
        peek(4'd8, 16'h0FFF, "R2");
        peek(4'd9, 16'h00FF, "R2");
        peek(4'd3, 16'h0000, "R2");
        // R5 flags on a pass of register 7
        cyc(mk(0, 2'b10, 2'b00, 0, 0, 0, 0, 0, 0, 0, 7), 16'h0);
        expect_now(2, 16'h1, "R5");
        expect_now(3, 16'h0, "R5");

        load_reg(4'd10, 16'hA5C3);
        load_reg(4'd11, 16'h0F0F);
        peek(4'd10, 16'hA5C3, "R7");
        peek(4'd11, 16'h0F0F, "R7");

        // R4 add
        cyc(mk(0, 2'b00, 2'b00, 1, 0, 0, 0, 0, 0, 11, 10), 16'h0);
        expect_now(2, 16'h1, "R5");
        expect_now(3, 16'h0, "R5");
        expect_next(0, 16'hB4D2, "R4");
        // R4 and
        cyc(mk(0, 2'b01, 2'b00, 1, 0, 0, 0, 0, 0, 11, 10), 16'h0);
        expect_next(0, 16'h0503, "R4");
        // R4 invert
        cyc(mk(0, 2'b11, 2'b00, 1, 0, 0, 0, 0, 0, 0, 10), 16'h0);
        expect_now(2, 16'h0, "R5");
        expect_next(0, 16'h5A3C, "R4");
        // R5 zero flag: 0xFFFF + 1 wraps to zero
        cyc(mk(0, 2'b00, 2'b00, 1, 0, 0, 0, 0, 0, 6, 7), 16'h0);
        expect_now(3, 16'h1, "R5");
        expect_now(2, 16'h0, "R5");
        expect_next(0, 16'h0000, "R4");

        // R3 buffer as left input
        peek(4'd10, 16'hA5C3, "R3");
        cyc(mk(1, 2'b00, 2'b00, 1, 0, 0, 0, 0, 0, 6, 11), 16'h0);
        expect_next(0, 16'hA5C4, "R3");

        // R6 shifts
        cyc(mk(0, 2'b10, 2'b01, 1, 0, 0, 0, 0, 0, 0, 10), 16'h0);
        expect_next(0, 16'h52E1, "R6");
        cyc(mk(0, 2'b10, 2'b10, 1, 0, 0, 0, 0, 0, 0, 10), 16'h0);
        expect_next(0, 16'h4B86, "R6");
        cyc(mk(0, 2'b10, 2'b11, 1, 0, 0, 0, 0, 0, 0, 10), 16'h0);
        expect_next(0, 16'hA5C3, "R6");
        cyc(mk(0, 2'b10, 2'b01, 1, 0, 0, 0, 0, 0, 0, 7), 16'h0);
        expect_next(0, 16'h7FFF, "R6");

        // R7 read-before-write: r12 := ~r12 (old 0), then ~r12 again
        cyc(mk(0, 2'b11, 2'b00, 1, 0, 0, 0, 1, 12, 0, 12), 16'h0);
        expect_now(2, 16'h1, "R7");
        expect_next(0, 16'hFFFF, "R7");
        cyc(mk(0, 2'b11, 2'b00, 1, 0, 0, 0, 0, 0, 0, 12), 16'h0);
        expect_now(3, 16'h1, "R7");
        expect_next(0, 16'h0000, "R7");

        // R9 address register, low 12 bits
        cyc(mk(0, 2'b00, 2'b00, 0, 1, 0, 0, 0, 0, 10, 0), 16'h0);
        expect_next(1, 16'h05C3, "R9");
        cyc(mk(0, 2'b00, 2'b00, 0, 1, 0, 0, 0, 0, 7, 0), 16'h0);
        expect_next(1, 16'h0FFF, "R9");
        cyc(32'h0, 16'h0);
        expect_now(1, 16'h0FFF, "R9");

        // R10 read capture, then data without a read is ignored
        cyc(mk(0, 2'b00, 2'b00, 0, 0, 1, 0, 0, 0, 0, 0), 16'h0);
        expect_now(4, 16'h1, "R11");
        expect_now(5, 16'h0, "R11");
        cyc(32'h0, 16'h1234);
        expect_next(0, 16'h1234, "R10");
        cyc(32'h0, 16'h7777);
        expect_next(0, 16'h1234, "R10");
        // R10 buffer load wins over returning data
        cyc(mk(0, 2'b00, 2'b00, 0, 0, 1, 0, 0, 0, 0, 0), 16'h0);
        cyc(mk(0, 2'b10, 2'b00, 1, 0, 0, 0, 0, 0, 0, 11), 16'h9999);
        expect_next(0, 16'h0F0F, "R10");

        // R11 write strobe
        cyc(mk(0, 2'b00, 2'b00, 0, 0, 0, 1, 0, 0, 0, 0), 16'h0);
        expect_now(5, 16'h1, "R11");
        expect_now(4, 16'h0, "R11");

        // R12 condition and next-address fields set: same add result
        cyc(mk(0, 2'b00, 2'b00, 1, 0, 0, 0, 0, 0, 11, 10) | 32'h6000_00FF, 16'h0);
        expect_now(2, 16'h1, "R12");
        expect_next(0, 16'hB4D2, "R12");

        cyc(32'h0, 16'h0);
        @(posedge clk); #2;
        if (q.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard left=%0d expected=0", q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule